// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

The decoder takes configuration data one byte at a time, in the order it arrives from a serial test-access data path. It mirrors the bit order of every byte and joins bytes in pairs into 16-bit words, with the first byte of a pair as the upper half. Filler words are skipped until a synchronisation word appears. After synchronisation, each word is read as a typed packet header or as the payload of one. Payload words of a single-register write land in a small register file.

A write of the internal-reprogram code to the command register raises a one-cycle reboot request. Two kinds of bad input are flagged as pulses. A word that is neither filler nor sync, seen while searching, gives an abort pulse. A malformed or unsupported header gives an error pulse.

Every write is also shown on a write-event port, and any register can be read back through a combinational read port. All pulses and write events appear two clock cycles after the edge that samples the second byte of the word concerned.

Top module: `cfg_pkt_decoder`

## Requirements
- R1: Each input byte is bit-reversed (input bit 7 becomes word bit 8 or bit 0). The first byte of a pair forms word bits 15:8 and the second forms bits 7:0.
- R2: The decoder acts only on complete words. A lone byte stays pending across idle cycles until its partner arrives. Reset discards a pending byte.
- R3: While searching for sync, the filler word 0xFFFF is skipped without any output.
- R4: The word 0xAA99 ends the search. A directly following 0x5566 is consumed silently. Any other following word is decoded as a header.
- R5: While searching, a word other than 0xFFFF or 0xAA99 gives a one-cycle abortPulse, and the search continues.
- R6: A header has TYPE in bits 15:13 (001 is type 1), OP in bits 12:11 (00 NOP, 01 READ, 10 WRITE), REGISTER in bits 10:5 and WORDCOUNT in bits 4:0. A type 1 WRITE with WORDCOUNT N>0 writes each of the next N words to REGISTER. Each write shows wrEn high for one cycle, with wrAddr and wrData, two cycles after the edge that samples the word's second byte.
- R7: A write of 0x000E to register 0x05 (for example, header 0x30A1 followed by 0x000E) raises rebootReq for exactly one cycle, in the same cycle as its wrEn. A write of any other value raises no rebootReq.
- R8: Type 1 NOP headers (such as 0x2000), READ headers, and WRITE headers with WORDCOUNT 0 are consumed with no output. The word after such a header is decoded as a header.
- R9: A header with REGISTER above 0x22, with TYPE other than 001 (type 2, value 010, is unsupported), or with OP 11 gives a one-cycle errPulse and returns the decoder to sync search.
- R10: rdData always shows the register selected by rdAddr. It reads 0 for addresses above 0x22.
- R11: A synchronous active-high reset clears the register file and all outputs, and returns the decoder to sync search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byteValid | input | 1 | byteIn carries a byte this cycle |
| byteIn | input | 8 | Incoming stream byte, unreversed |
| rdAddr | input | 6 | Register file read address |
| rdData | output | 16 | Register file read data (combinational) |
| wrEn | output | 1 | One-cycle write event |
| wrAddr | output | 6 | Register written by the event |
| wrData | output | 16 | Value written by the event |
| rebootReq | output | 1 | One-cycle internal-reprogram request |
| abortPulse | output | 1 | Bad word during sync search |
| errPulse | output | 1 | Bad or unsupported header |

## Verification
The bench uses the default parameters: 35 registers, command register at 0x05, reprogram code 0x000E, and sync and filler words as listed. With these values, writes to the last legal address 0x22 can be tested, and so can the error on 0x23. A scoreboard compares every write, reboot, abort and error event, in order, against what the bench expects. The streams cover back-to-back bytes, bytes with idle gaps, a reset in the middle of a pair, and multi-word payloads.

// File: rtl/cfg_pkt_pkg.sv
package cfg_pkt_pkg;
  localparam int REG_AW = 6;   // REGISTER field width in a header
  localparam int CNT_W  = 5;   // WORDCOUNT field width

  typedef enum logic [1:0] {
    ST_SEARCH,
    ST_POSTSYNC,
    ST_HEADER,
    ST_PAYLOAD
  } decState_t;

  typedef struct packed {
    logic              wrEn;
    logic              reboot;
    logic              abortSync;
    logic              hdrErr;
    logic [REG_AW-1:0] addr;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfg_pkt_datapath.sv
module cfg_pkt_datapath
  import cfg_pkt_pkg::*;
#(
  parameter int NUM_REGS = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  input  ctrlStrobe_t       strobe,
  output logic              wordValid,
  output logic [15:0]       word,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [15:0]       rdData,
  output logic              wrEn,
  output logic [REG_AW-1:0] wrAddr,
  output logic [15:0]       wrData,
  output logic              rebootReq,
  output logic              abortPulse,
  output logic              errPulse
);
  localparam logic [REG_AW-1:0] LAST_ADDR = REG_AW'(NUM_REGS - 1);

  logic [7:0]  revByte;
  logic [7:0]  hiByte;
  logic        hiPending;
  logic [15:0] regFile [NUM_REGS];

  for (genvar i = 0; i < 8; i++) begin : g_rev
    assign revByte[i] = byteIn[7-i];
  end

  // Pair assembly: first byte is upper half
  always_ff @(posedge clk) begin
    if (rst) begin
      hiPending <= 1'b0;
      hiByte    <= '0;
      wordValid <= 1'b0;
      word      <= '0;
    end else begin
      wordValid <= 1'b0;
      if (byteValid) begin
        if (hiPending) begin
          word      <= {hiByte, revByte};
          wordValid <= 1'b1;
          hiPending <= 1'b0;
        end else begin
          hiByte    <= revByte;
          hiPending <= 1'b1;
        end
      end
    end
  end

  // Registered event outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      wrEn       <= 1'b0;
      wrAddr     <= '0;
      wrData     <= '0;
      rebootReq  <= 1'b0;
      abortPulse <= 1'b0;
      errPulse   <= 1'b0;
    end else begin
      wrEn       <= strobe.wrEn;
      wrAddr     <= strobe.addr;
      wrData     <= word;
      rebootReq  <= strobe.reboot;
      abortPulse <= strobe.abortSync;
      errPulse   <= strobe.hdrErr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_REGS; k++) regFile[k] <= '0;
    end else if (strobe.wrEn && strobe.addr <= LAST_ADDR) begin
      regFile[strobe.addr] <= word;
    end
  end

  assign rdData = (rdAddr <= LAST_ADDR) ? regFile[rdAddr] : '0;
endmodule

// File: rtl/cfg_pkt_ctrl.sv
module cfg_pkt_ctrl
  import cfg_pkt_pkg::*;
#(
  parameter logic [REG_AW-1:0] MAX_ADDR = 6'h22,
  parameter logic [REG_AW-1:0] CMD_ADDR = 6'h05,
  parameter logic [15:0]       IPROG    = 16'h000E,
  parameter logic [15:0]       SYNC     = 16'hAA99,
  parameter logic [15:0]       SYNC_ALT = 16'h5566,
  parameter logic [15:0]       DUMMY    = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wordValid,
  input  logic [15:0] word,
  output ctrlStrobe_t strobe
);
  decState_t         state, nextState;
  logic [CNT_W-1:0]  cnt, nextCnt;
  logic [REG_AW-1:0] addrQ, nextAddr;

  logic [2:0]        hdrType;
  logic [1:0]        hdrOp;
  logic [REG_AW-1:0] hdrReg;
  logic [CNT_W-1:0]  hdrCnt;
  logic              doHeader;

  assign hdrType = word[15:13];
  assign hdrOp   = word[12:11];
  assign hdrReg  = word[10:5];
  assign hdrCnt  = word[4:0];
  assign doHeader = wordValid &&
                    (state == ST_HEADER || (state == ST_POSTSYNC && word != SYNC_ALT));

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    nextAddr  = addrQ;
    strobe    = '0;
    strobe.addr = addrQ;
    if (wordValid) begin
      case (state)
        ST_SEARCH: begin
          if (word == SYNC)       nextState = ST_POSTSYNC;
          else if (word != DUMMY) strobe.abortSync = 1'b1;
        end
        ST_PAYLOAD: begin
          strobe.wrEn   = 1'b1;
          strobe.reboot = (addrQ == CMD_ADDR) && (word == IPROG);
          nextCnt       = CNT_W'(cnt - 1'b1);
          if (cnt == CNT_W'(1)) nextState = ST_HEADER;
        end
        default: nextState = ST_HEADER;  // POSTSYNC alt-sync or HEADER
      endcase
    end
    if (doHeader) begin
      nextState = ST_HEADER;
      if (hdrType != 3'b001 || hdrOp == 2'b11 || hdrReg > MAX_ADDR) begin
        strobe.hdrErr = 1'b1;
        nextState     = ST_SEARCH;
      end else if (hdrOp == 2'b10 && hdrCnt != '0) begin
        nextState = ST_PAYLOAD;
        nextCnt   = hdrCnt;
        nextAddr  = hdrReg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SEARCH;
      cnt   <= '0;
      addrQ <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      addrQ <= nextAddr;
    end
  end
endmodule

// File: rtl/cfg_pkt_decoder.sv
module cfg_pkt_decoder
  import cfg_pkt_pkg::*;
#(
  parameter int          NUM_REGS = 35,
  parameter logic [5:0]  CMD_ADDR = 6'h05,
  parameter logic [15:0] IPROG    = 16'h000E,
  parameter logic [15:0] SYNC     = 16'hAA99,
  parameter logic [15:0] SYNC_ALT = 16'h5566,
  parameter logic [15:0] DUMMY    = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byteValid,
  input  logic [7:0]  byteIn,
  input  logic [5:0]  rdAddr,
  output logic [15:0] rdData,
  output logic        wrEn,
  output logic [5:0]  wrAddr,
  output logic [15:0] wrData,
  output logic        rebootReq,
  output logic        abortPulse,
  output logic        errPulse
);
  localparam logic [REG_AW-1:0] MAX_ADDR = REG_AW'(NUM_REGS - 1);

  ctrlStrobe_t strobe;
  logic        wordValid;
  logic [15:0] word;

  cfg_pkt_ctrl #(
    .MAX_ADDR(MAX_ADDR), .CMD_ADDR(CMD_ADDR), .IPROG(IPROG),
    .SYNC(SYNC), .SYNC_ALT(SYNC_ALT), .DUMMY(DUMMY)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wordValid(wordValid), .word(word), .strobe(strobe)
  );

  cfg_pkt_datapath #(.NUM_REGS(NUM_REGS)) dp_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteIn(byteIn),
    .strobe(strobe), .wordValid(wordValid), .word(word),
    .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rebootReq(rebootReq), .abortPulse(abortPulse), .errPulse(errPulse)
  );
endmodule

// File: rtl/cfg_pkt_decoder_chk.sv
module cfg_pkt_decoder_chk #(
  parameter logic [5:0]  CMD_ADDR = 6'h05,
  parameter logic [15:0] IPROG    = 16'h000E,
  parameter logic [5:0]  MAX_ADDR = 6'h22
) (
  input logic        clk,
  input logic        rst,
  input logic        byteValid,
  input logic        wrEn,
  input logic [5:0]  wrAddr,
  input logic [15:0] wrData,
  input logic        rebootReq,
  input logic        abortPulse,
  input logic        errPulse
);
  // R7
  reboot_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rebootReq |=> !rebootReq);

  // R7
  reboot_on_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    rebootReq |-> (wrEn && wrAddr == CMD_ADDR && wrData == IPROG));

  // R9
  wr_addr_legal_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (wrAddr <= MAX_ADDR));

  // R5
  event_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({wrEn, abortPulse, errPulse}) <= 1);

  // R2
  event_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn || abortPulse || errPulse) |-> $past(byteValid, 2));
endmodule

bind cfg_pkt_decoder cfg_pkt_decoder_chk #(
  .CMD_ADDR(CMD_ADDR), .IPROG(IPROG), .MAX_ADDR(MAX_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .byteValid(byteValid), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .rebootReq(rebootReq), .abortPulse(abortPulse), .errPulse(errPulse)
);

// File: tb/cfg_pkt_decoder_tb_top.sv
module cfg_pkt_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic [5:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        wrEn;
  logic [5:0]  wrAddr;
  logic [15:0] wrData;
  logic        rebootReq, abortPulse, errPulse;

  int vecCnt = 0;
  int failCnt = 0;

  typedef struct {
    logic        wr, rb, ab, er;
    logic [5:0]  addr;
    logic [15:0] data;
    string       req;
  } evItem_t;

  evItem_t expQ[$];

  always #2 clk = ~clk;  // 250 MHz

  cfg_pkt_decoder dut_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteIn(byteIn),
    .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rebootReq(rebootReq), .abortPulse(abortPulse),
    .errPulse(errPulse)
  );

  function automatic logic [7:0] mirror8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  function automatic logic [15:0] hdr(input logic [1:0] op, input logic [5:0] rg,
                                      input logic [4:0] n);
    return {3'b001, op, rg, n};
  endfunction

  task automatic putByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteIn    = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b0;
    end
  endtask

  // word as it would appear on the wire (R1)
  task automatic sendWord(input logic [15:0] w);
    putByte(mirror8(w[15:8]));
    putByte(mirror8(w[7:0]));
  endtask

  task automatic expWrite(input logic [5:0] a, input logic [15:0] d, input logic rb,
                          input string req);
    evItem_t e;
    e.wr = 1; e.rb = rb; e.ab = 0; e.er = 0; e.addr = a; e.data = d; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic expFlag(input logic ab, input logic er, input string req);
    evItem_t e;
    e.wr = 0; e.rb = 0; e.ab = ab; e.er = er; e.addr = '0; e.data = '0; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic doReset();
    idle(4);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic checkVal(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkRead(input string req, input logic [5:0] a, input logic [15:0] exp);
    @(negedge clk);
    rdAddr = a;
    #1;
    checkVal(req, rdData, exp);
  endtask

  // Monitor: pop and compare each event as it appears
  always @(negedge clk) begin
    if (!rst && (wrEn || rebootReq || abortPulse || errPulse)) begin
      vecCnt++;
      if (expQ.size() == 0) begin
        failCnt++;
        $display("FAIL unexpected event: actual wr=%b rb=%b ab=%b er=%b a=%h d=%h expected none",
                 wrEn, rebootReq, abortPulse, errPulse, wrAddr, wrData);
      end else begin
        evItem_t e;
        e = expQ.pop_front();
        if (e.wr !== wrEn || e.rb !== rebootReq || e.ab !== abortPulse ||
            e.er !== errPulse || (e.wr && (e.addr !== wrAddr || e.data !== wrData))) begin
          failCnt++;
          $display("FAIL %s: actual wr=%b rb=%b ab=%b er=%b a=%h d=%h expected wr=%b rb=%b ab=%b er=%b a=%h d=%h",
                   e.req, wrEn, rebootReq, abortPulse, errPulse, wrAddr, wrData,
                   e.wr, e.rb, e.ab, e.er, e.addr, e.data);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R11 reset state
    @(negedge clk);
    checkVal("R11", {12'd0, wrEn, rebootReq, abortPulse, errPulse}, 16'h0);
    checkRead("R11", 6'h05, 16'h0);

    // R3 R4 R6 R7 R8: fillers, sync, reprogram write, NOPs
    expWrite(6'h05, 16'h000E, 1'b1, "R7");
    sendWord(16'hFFFF); sendWord(16'hFFFF); sendWord(16'hAA99);
    sendWord(16'h30A1); sendWord(16'h000E);
    sendWord(16'h2000); sendWord(16'h2000);
    idle(6);
    checkRead("R6", 6'h05, 16'h000E);

    // R4 second sync word accepted; R5 abort while searching
    doReset();
    expFlag(1'b1, 1'b0, "R5");
    expWrite(6'h01, 16'h1234, 1'b0, "R6");
    expWrite(6'h01, 16'hABCD, 1'b0, "R6");
    sendWord(16'h3F3F);
    sendWord(16'hAA99); sendWord(16'h5566);
    sendWord(hdr(2'b10, 6'h01, 5'd2)); sendWord(16'h1234); sendWord(16'hABCD);
    idle(6);
    checkRead("R10", 6'h01, 16'hABCD);

    // R7 other value to command register: no reboot
    expWrite(6'h05, 16'h0007, 1'b0, "R7");
    sendWord(16'h30A1); sendWord(16'h0007);
    // R8 READ and zero-count WRITE consumed silently
    expWrite(6'h02, 16'h0055, 1'b0, "R8");
    sendWord(hdr(2'b01, 6'h03, 5'd1));
    sendWord(hdr(2'b10, 6'h04, 5'd0));
    sendWord(hdr(2'b10, 6'h02, 5'd1)); sendWord(16'h0055);
    // boundary: last legal address
    expWrite(6'h22, 16'h0F0F, 1'b0, "R9");
    sendWord(hdr(2'b10, 6'h22, 5'd1)); sendWord(16'h0F0F);
    // R9 address 0x23 -> error and back to search, where 0x2000 aborts
    expFlag(1'b0, 1'b1, "R9");
    expFlag(1'b1, 1'b0, "R9");
    sendWord(hdr(2'b10, 6'h23, 5'd1)); sendWord(16'h2000);
    idle(6);
    checkRead("R10", 6'h22, 16'h0F0F);
    checkRead("R10", 6'h23, 16'h0000);
    checkRead("R8", 6'h04, 16'h0000);

    // R9 type 2 header unsupported; OP 11 rejected
    expFlag(1'b0, 1'b1, "R9");
    expFlag(1'b0, 1'b1, "R9");
    sendWord(16'hAA99); sendWord(16'h5000);
    sendWord(16'hAA99); sendWord(hdr(2'b11, 6'h01, 5'd0));
    idle(6);

    // R2 bytes with idle gaps in between
    expWrite(6'h06, 16'hC35A, 1'b0, "R2");
    putByte(mirror8(8'hAA)); idle(3); putByte(mirror8(8'h99)); idle(2);
    putByte(mirror8(8'h30)); idle(5); putByte(mirror8(8'hC1)); idle(1);
    putByte(mirror8(8'hC3)); idle(4); putByte(mirror8(8'h5A)); idle(6);
    checkRead("R1", 6'h06, 16'hC35A);

    // R2 reset mid-pair discards the pending byte
    putByte(mirror8(8'h12)); idle(1);
    doReset();
    checkRead("R11", 6'h06, 16'h0000);
    expWrite(6'h05, 16'h000E, 1'b1, "R2");
    sendWord(16'hAA99); sendWord(16'h30A1); sendWord(16'h000E);
    idle(8);

    checkVal("R6", 16'(expQ.size()), 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule